// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits between the command sequencer of a synchronous DRAM controller and the column address pins. When a column access starts, it is given a 10-bit starting column and the burst settings that were programmed for that access. It then produces one column address per clock, one for each data beat. The order of the addresses follows the selected burst type. A fixed-length burst finishes by itself. A full-page burst keeps running until a stop request arrives.

Ordering can be sequential or interleaved. In sequential order, the low bits of the column count upward and wrap inside the aligned burst window, while the upper bits stay fixed. In interleaved order, the beat number is XORed into the low bits of the start column. In full-page mode, the whole column counts upward and wraps modulo the page size.

The settings are captured together with the start pulse, so the controller can change them freely between bursts. A new start may follow the last beat directly, with no idle cycle between bursts. A start that arrives during a burst abandons the old burst and begins the new one.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and after it is released, `beat_vld_o` and `last_o` are 0 and `col_o` is 0.
- R2: When `start_i` is high at a rising edge, the generator captures `start_col_i`, `blen_i` and `ilv_i` at that edge. From that edge on, beat 0 is shown with `beat_vld_o`=1 and `col_o` equal to the captured start column.
- R3: `blen_i` selects the burst length: 3'b000 is 1 beat, 3'b001 is 2 beats, 3'b010 is 4 beats and 3'b011 is 8 beats. Any code with bit 2 set is full page. A fixed burst with no stop and no new start shows exactly that many valid beats, one per clock, and `beat_vld_o` then falls.
- R4: With `ilv_i`=0 and a fixed length BL, beat k has the upper bits of the start column. Its low log2(BL) bits are (start low bits + k) mod BL.
- R5: With `ilv_i`=1 and a fixed length BL, beat k is the start column with k XORed into its low log2(BL) bits.
- R6: In full-page mode, beat k is (start + k) mod 1024, whatever the value of `ilv_i`. The burst continues without end until it is stopped or restarted.
- R7: `last_o` is 1 exactly on beat BL-1 of a fixed burst. It is never 1 in full-page mode.
- R8: When `stop_i` is high at an edge while `start_i` is low, any burst in progress ends, and `beat_vld_o` is 0 after that edge. When no burst is running, `stop_i` has no effect.
- R9: When `start_i` is high at an edge during a burst, including on its last beat and including when `stop_i` is also high, the new burst's beat 0 follows directly, with no idle cycle.
- R10: While `beat_vld_o` is 0, `col_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst at this edge |
| start_col_i | input | 10 | Starting column of the burst |
| blen_i | input | 3 | Burst length code (see R3) |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | End the burst in progress |
| col_o | output | 10 | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
Two functions of the block can fall in the same cycle, and the bench provokes both cases on purpose.

The first case is a restart together with a burst end. A new start is raised on the very cycle that shows the last beat of a fixed burst. A separate test raises start and stop at the same edge during a full-page burst. In both tests the bench expects beat 0 of the new burst on the next cycle, with no gap.

The second case is a stop arriving in the middle of a fixed burst. The bench expects this stop to cut the burst short without `last_o` ever rising.

Expected columns come from a modular-arithmetic model of each ordering. The bench computes them on its own and does not reuse the mask form that the RTL uses.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             last_o
);
  localparam int LOW_W = 3;

  logic             act_q, fp_q, ilv_q;
  logic [LOW_W-1:0] mask_q;
  logic [COL_W-1:0] base_q, idx_q;

  logic [COL_W-1:0] mask_w, sum_w, seq_col, ilv_col;
  logic             last_w;

  function automatic logic [LOW_W-1:0] len_mask(input logic [1:0] code);
    case (code)
      2'd0:    len_mask = 3'd0;
      2'd1:    len_mask = 3'd1;
      2'd2:    len_mask = 3'd3;
      default: len_mask = 3'd7;
    endcase
  endfunction

  assign mask_w  = {{(COL_W-LOW_W){1'b0}}, mask_q};
  assign sum_w   = base_q + idx_q;
  assign seq_col = (base_q & ~mask_w) | (sum_w & mask_w);
  assign ilv_col = base_q ^ (idx_q & mask_w);
  assign last_w  = act_q && !fp_q && (idx_q[LOW_W-1:0] == mask_q);

  assign beat_vld_o = act_q;
  assign last_o     = last_w;
  assign col_o      = !act_q ? '0 : fp_q ? sum_w : ilv_q ? ilv_col : seq_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      fp_q   <= 1'b0;
      ilv_q  <= 1'b0;
      mask_q <= '0;
      base_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      fp_q   <= blen_i[2];
      ilv_q  <= ilv_i;
      mask_q <= len_mask(blen_i[1:0]);
      base_q <= start_col_i;
      idx_q  <= '0;
    end else if (act_q) begin
      if (stop_i || last_w) act_q <= 1'b0;
      else                  idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       blen_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_vld_o,
  input logic             last_o
);
  logic fp_seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fp_seen <= 1'b0;
    else if (start_i) fp_seen <= blen_i[2];

  a_r2_start_gives_beat0: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> beat_vld_o && col_o == $past(start_col_i));
  a_r7_last_only_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> beat_vld_o);
  a_r7_no_last_full_page: assert property (@(posedge clk) disable iff (!rst_n)
    fp_seen && beat_vld_o |-> !last_o);
  a_r3_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !start_i |=> !beat_vld_o);
  a_r8_stop_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !beat_vld_o);
  a_r6_full_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld_o && fp_seen && !start_i && !stop_i |=> col_o == $past(col_o) + COL_W'(1));
  a_r4_upper_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld_o && !fp_seen && !start_i && !stop_i && !last_o |=> col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]));
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_vld_o |-> col_o == '0);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  logic clk = 0, rst_n = 0, start_i = 0, ilv_i = 0, stop_i = 0;
  logic [9:0] start_col_i = 0;
  logic [2:0] blen_i = 0;
  logic [9:0] col_o;
  logic beat_vld_o, last_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_col_gen i_burst_col_gen (.*);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_col(int base, int k, int bl, bit il, bit fp);
    int lo;
    if (fp) return (base + k) % 1024;
    lo = base % bl;
    if (il) return base - lo + (lo ^ k);
    return base - lo + ((lo + k) % bl);
  endfunction

  task automatic go(int base, int code, bit il, bit stp = 0);
    start_i = 1; start_col_i = base[9:0]; blen_i = code[2:0]; ilv_i = il; stop_i = stp;
    @(negedge clk);
    start_i = 0; stop_i = 0;
  endtask

  task automatic beats(string tag, int base, int code, bit il, int from, int n);
    int bl = code[2] ? 1024 : (1 << code);
    for (int k = from; k < from + n; k++) begin
      chk({tag, " col"}, col_o, exp_col(base, k, bl, il, code[2]));
      chk({tag, " vld"}, beat_vld_o, 1);
      chk({tag, " last R7"}, last_o, (!code[2] && k == bl - 1) ? 1 : 0);
      if (k < from + n - 1) @(negedge clk);
    end
  endtask

  task automatic idle_chk(string tag);
    chk({tag, " vld"}, beat_vld_o, 0);
    chk({tag, " last"}, last_o, 0);
    chk({tag, " col R10"}, col_o, 0);
  endtask

  task automatic t_fixed(string tag, int base, int code, bit il);
    @(negedge clk);
    go(base, code, il);
    beats(tag, base, code, il, 0, 1 << code);
    @(negedge clk);
    idle_chk({tag, " end R3"});
  endtask

  task automatic t_full_page;
    @(negedge clk);
    go(10'h3FE, 4, 1);
    beats("R6 full page", 10'h3FE, 4, 1, 0, 12);
    stop_i = 1;
    @(negedge clk);
    stop_i = 0;
    idle_chk("R8 stop full page");
  endtask

  task automatic t_stop_mid;
    @(negedge clk);
    go(10'h300, 3, 0);
    beats("R8 mid", 10'h300, 3, 0, 0, 3);
    stop_i = 1;
    @(negedge clk);
    stop_i = 0;
    idle_chk("R8 stop mid burst");
  endtask

  task automatic t_stop_idle;
    @(negedge clk);
    stop_i = 1;
    @(negedge clk);
    stop_i = 0;
    idle_chk("R8 idle stop");
    @(negedge clk);
    idle_chk("R8 idle stop later");
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    go(10'h101, 1, 0);
    beats("R9 b2b A", 10'h101, 1, 0, 0, 2);
    go(10'h2A6, 2, 1);
    beats("R9 b2b B", 10'h2A6, 2, 1, 0, 4);
    @(negedge clk);
    idle_chk("R9 b2b end");
  endtask

  task automatic t_abort;
    @(negedge clk);
    go(10'h020, 3, 0);
    beats("R9 abort A", 10'h020, 3, 0, 0, 3);
    go(10'h047, 2, 1);
    beats("R9 abort B", 10'h047, 2, 1, 0, 4);
    @(negedge clk);
    idle_chk("R9 abort end");
  endtask

  task automatic t_start_stop;
    @(negedge clk);
    go(10'h3F0, 5, 0);
    beats("R9 ss fp", 10'h3F0, 5, 0, 0, 2);
    go(10'h088, 3, 1, 1);
    beats("R9 start+stop", 10'h088, 3, 1, 0, 8);
    @(negedge clk);
    idle_chk("R9 start+stop end");
  endtask

  initial begin
    #1;
    idle_chk("R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    idle_chk("R1 after reset");
    t_fixed("R4 seq8", 10'h15D, 3, 0);
    t_fixed("R5 ilv8", 10'h15D, 3, 1);
    t_fixed("R4 seq4", 10'h2F6, 2, 0);
    t_fixed("R5 ilv4", 10'h2F6, 2, 1);
    t_fixed("R5 ilv2", 10'h0C3, 1, 1);
    t_fixed("R3 len1", 10'h3FF, 0, 0);
    t_full_page();
    t_stop_mid();
    t_stop_idle();
    t_back_to_back();
    t_abort();
    t_start_stop();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule